// File: doc/BRIEF.md
# Segmented Accumulator Port with Section Preload

This block is the output and preload logic for a 35-bit multiply-accumulate result register. The register is split into three sections: a 3-bit extension (bits 34..32), a 16-bit upper half (bits 31..16) and a 16-bit lower half (bits 15..0). Each section faces the outside through its own bidirectional port. Each port is modelled as a separate data input, data output and output enable. The lower port is also the entry path for the Y operand of the multiplier.

A single preload control and three active-low section enables together choose how each section behaves. With preload low, an enable that is low makes its port drive the section's contents, and an enable that is high leaves the port undriven. A product strobe then loads the arithmetic result into all three sections. With preload high, every port is undriven. A section whose enable is high takes the value on its port input at the next product strobe. A section whose enable is low is left unchanged. The arithmetic itself lies outside this block and arrives on `sum_in`.

Top module: `acc_port_seg`

## Requirements
- R1: The 35-bit result on `sum_in` maps to the sections by bit position: bits 34..32 go to the extension section, bits 31..16 to the upper section and bits 15..0 to the lower section, and each section appears on its own output port.
- R2: With `preload` low, a section's output enable is high exactly when that section's active-low enable input is low, and the port then carries the section's stored contents.
- R3: With `preload` high, all three output enables are low, whatever the section enables are.
- R4: With `preload` high, a product strobe writes each section whose enable input is high from that section's port input.
- R5: With `preload` high, a section whose enable input is low keeps its previous contents across a product strobe.
- R6: With `preload` low, a product strobe loads `sum_in` into all three sections, whatever the section enables are.
- R7: Without a product strobe, no section changes, whatever `sum_in`, the port inputs and the controls do.
- R8: `y_ready` is high exactly when the lower port is not driven, so that the shared lower port can accept Y operand data.
- R9: A synchronous active-high reset clears all three sections to zero.
- R10: The output enables and `y_ready` follow `preload` and the section enables combinationally, within the same cycle and without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Product strobe; the register updates on this cycle's edge |
| preload | input | 1 | High selects preload through the ports |
| ext_oe_n | input | 1 | Extension section enable, active low |
| hi_oe_n | input | 1 | Upper section enable, active low |
| lo_oe_n | input | 1 | Lower section enable, active low |
| sum_in | input | 35 | Accumulated result from the arithmetic |
| ext_pin_i | input | 3 | Extension port input data |
| hi_pin_i | input | 16 | Upper port input data |
| lo_pin_i | input | 16 | Lower port input data, shared with the Y operand |
| ext_pin_o | output | 3 | Extension section contents |
| hi_pin_o | output | 16 | Upper section contents |
| lo_pin_o | output | 16 | Lower section contents |
| ext_pin_oe | output | 1 | Extension port drive enable |
| hi_pin_oe | output | 1 | Upper port drive enable |
| lo_pin_oe | output | 1 | Lower port drive enable |
| y_ready | output | 1 | Lower port is free for Y operand entry |

## Verification
All sixteen combinations of preload and the three section enables are walked, one after another. For each combination the bench checks the drive pattern and the shared-port flag before any clock edge. It then issues a strobe and reads the sections back through the ports. A design that inverts the sense of an enable in preload mode would write the wrong sections or drive a port during preload. A design that gates the normal load with the enables would leave stale data in the sections that are not driving. Separate directed cases look at reset clearing, holding without a strobe, and the bit split of a result with a set bit at each section edge. A design with an off-by-one slice would move those bits into the wrong section.

// File: rtl/acc_port_pkg.sv
`timescale 1ns/1ps
package acc_port_pkg;

  typedef enum logic [1:0] {
    SEG_IDLE    = 2'd0,
    SEG_DRIVE   = 2'd1,
    SEG_PRELOAD = 2'd2
  } seg_mode_e;

  // Per-section mode from the shared preload control and the section's
  // active-low enable; the enable's meaning flips with the preload control.
  function automatic seg_mode_e seg_mode(input logic preload, input logic oe_n);
    if (preload) return oe_n ? SEG_PRELOAD : SEG_IDLE;
    else         return oe_n ? SEG_IDLE    : SEG_DRIVE;
  endfunction

endpackage

// File: rtl/seg_decode.sv
`timescale 1ns/1ps
module seg_decode
  import acc_port_pkg::*;
(
  input  logic preload,
  input  logic oe_n,
  output logic drive,
  output logic pl_wr
);

  seg_mode_e mode;

  always_comb begin
    mode  = seg_mode(preload, oe_n);
    drive = (mode == SEG_DRIVE);
    pl_wr = (mode == SEG_PRELOAD);
  end

endmodule

// File: rtl/seg_reg.sv
`timescale 1ns/1ps
module seg_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         preload,
  input  logic         pl_wr,
  input  logic [W-1:0] d_pl,
  input  logic [W-1:0] d_sum,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (strobe) begin
      if (!preload)   q <= d_sum;
      else if (pl_wr) q <= d_pl;
    end
  end

  AST_PL_WRITE:   assert property (@(posedge clk) disable iff (rst)
                    (strobe && preload && pl_wr) |=> (q == $past(d_pl)));   // R4
  AST_PL_HOLD:    assert property (@(posedge clk) disable iff (rst)
                    (strobe && preload && !pl_wr) |=> $stable(q));          // R5
  AST_SUM_LOAD:   assert property (@(posedge clk) disable iff (rst)
                    (strobe && !preload) |=> (q == $past(d_sum)));          // R6
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    !strobe |=> $stable(q));                                // R7
  AST_RESET_ZERO: assert property (@(posedge clk)
                    rst |=> (q == '0));                                     // R9

endmodule

// File: rtl/seg_slice.sv
`timescale 1ns/1ps
module seg_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         preload,
  input  logic         oe_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] sum_part,
  output logic [W-1:0] pin_o,
  output logic         pin_oe
);

  logic pl_wr;

  seg_decode u_dec (
    .preload (preload),
    .oe_n    (oe_n),
    .drive   (pin_oe),
    .pl_wr   (pl_wr)
  );

  seg_reg #(.W(W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .preload (preload),
    .pl_wr   (pl_wr),
    .d_pl    (pin_i),
    .d_sum   (sum_part),
    .q       (pin_o)
  );

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
                           pl_wr |-> !pin_oe);                              // R3

endmodule

// File: rtl/acc_port_seg.sv
`timescale 1ns/1ps
module acc_port_seg #(
  parameter int EXT_W = 3,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16,
  localparam int ACC_W = EXT_W + HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             preload,
  input  logic             ext_oe_n,
  input  logic             hi_oe_n,
  input  logic             lo_oe_n,
  input  logic [ACC_W-1:0] sum_in,
  input  logic [EXT_W-1:0] ext_pin_i,
  input  logic [HI_W-1:0]  hi_pin_i,
  input  logic [LO_W-1:0]  lo_pin_i,
  output logic [EXT_W-1:0] ext_pin_o,
  output logic [HI_W-1:0]  hi_pin_o,
  output logic [LO_W-1:0]  lo_pin_o,
  output logic             ext_pin_oe,
  output logic             hi_pin_oe,
  output logic             lo_pin_oe,
  output logic             y_ready
);

  localparam int HI_LSB  = LO_W;
  localparam int EXT_LSB = LO_W + HI_W;

  seg_slice #(.W(EXT_W)) u_ext (
    .clk (clk), .rst (rst), .strobe (strobe), .preload (preload),
    .oe_n (ext_oe_n), .pin_i (ext_pin_i),
    .sum_part (sum_in[EXT_LSB +: EXT_W]),
    .pin_o (ext_pin_o), .pin_oe (ext_pin_oe)
  );

  seg_slice #(.W(HI_W)) u_hi (
    .clk (clk), .rst (rst), .strobe (strobe), .preload (preload),
    .oe_n (hi_oe_n), .pin_i (hi_pin_i),
    .sum_part (sum_in[HI_LSB +: HI_W]),
    .pin_o (hi_pin_o), .pin_oe (hi_pin_oe)
  );

  seg_slice #(.W(LO_W)) u_lo (
    .clk (clk), .rst (rst), .strobe (strobe), .preload (preload),
    .oe_n (lo_oe_n), .pin_i (lo_pin_i),
    .sum_part (sum_in[LO_W-1:0]),
    .pin_o (lo_pin_o), .pin_oe (lo_pin_oe)
  );

  assign y_ready = ~lo_pin_oe;

  AST_PRELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
                       preload |-> !(ext_pin_oe || hi_pin_oe || lo_pin_oe)); // R3
  AST_DRIVE_ENABLED: assert property (@(posedge clk) disable iff (rst)
                       (!preload && !hi_oe_n) |-> hi_pin_oe);                // R2
  AST_Y_FREE:        assert property (@(posedge clk) disable iff (rst)
                       (preload || lo_oe_n) |-> y_ready);                    // R8

endmodule

// File: tb/tb_acc_port_seg.sv
`timescale 1ns/1ps
module tb_acc_port_seg;

  logic        clk = 1'b0;
  logic        rst, strobe, preload, ext_oe_n, hi_oe_n, lo_oe_n;
  logic [34:0] sum_in;
  logic [2:0]  ext_pin_i;
  logic [15:0] hi_pin_i, lo_pin_i;
  logic [2:0]  ext_pin_o;
  logic [15:0] hi_pin_o, lo_pin_o;
  logic        ext_pin_oe, hi_pin_oe, lo_pin_oe, y_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  acc_port_seg dut (.*);

  // {preload, ext_n, hi_n, lo_n} is the index; entry = {drive[2:0], write[2:0]} ext,hi,lo
  localparam logic [5:0] TBL [16] = '{
    6'b111_000, 6'b110_000, 6'b101_000, 6'b100_000,
    6'b011_000, 6'b010_000, 6'b001_000, 6'b000_000,
    6'b000_000, 6'b000_001, 6'b000_010, 6'b000_011,
    6'b000_100, 6'b000_101, 6'b000_110, 6'b000_111
  };

  localparam logic [34:0] BASE = {3'b101, 16'hA5A5, 16'h3C3C};
  localparam logic [34:0] SUM2 = {3'b011, 16'h0F0F, 16'h7777};
  localparam logic [34:0] PLV  = {3'b010, 16'h1234, 16'hBEEF};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
  endtask

  task automatic readback(input string req, input logic [34:0] exp);
    @(negedge clk);
    preload = 1'b0; ext_oe_n = 1'b0; hi_oe_n = 1'b0; lo_oe_n = 1'b0;
    #1;
    chk(req, {29'd0, ext_pin_o, hi_pin_o, lo_pin_o}, {29'd0, exp});
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; strobe = 1'b0; preload = 1'b0;
    ext_oe_n = 1'b1; hi_oe_n = 1'b1; lo_oe_n = 1'b1;
    sum_in = BASE; ext_pin_i = '0; hi_pin_i = '0; lo_pin_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    readback("R9 reset clears", 35'd0);

    // Table walk: R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < 16; i++) begin
      logic [3:0]  c;
      logic [34:0] exp;
      c = 4'(i);
      @(negedge clk);
      preload = 1'b0; sum_in = BASE;
      pulse();
      @(negedge clk);
      preload = c[3]; ext_oe_n = c[2]; hi_oe_n = c[1]; lo_oe_n = c[0];
      sum_in = SUM2;
      {ext_pin_i, hi_pin_i, lo_pin_i} = PLV;
      #1;  // R10: combinational, no clock edge yet
      chk($sformatf("R2/R3/R10 drive ctrl=%b", c),
          {61'd0, ext_pin_oe, hi_pin_oe, lo_pin_oe}, {61'd0, TBL[i][5:3]});
      chk($sformatf("R8 y_ready ctrl=%b", c), {63'd0, y_ready}, {63'd0, ~TBL[i][3]});
      pulse();
      if (!c[3]) exp = SUM2;    // R6
      else begin                // R4 / R5
        exp[34:32] = TBL[i][2] ? PLV[34:32] : BASE[34:32];
        exp[31:16] = TBL[i][1] ? PLV[31:16] : BASE[31:16];
        exp[15:0]  = TBL[i][0] ? PLV[15:0]  : BASE[15:0];
      end
      readback($sformatf("R4/R5/R6 contents ctrl=%b", c), exp);
    end

    // R1: bit split at section edges
    @(negedge clk);
    preload = 1'b0; sum_in = 35'h4_8000_8001;
    pulse();
    readback("R1 section split", 35'h4_8000_8001);
    chk("R1 ext field", {61'd0, ext_pin_o}, 64'h4);
    chk("R1 hi field", {48'd0, hi_pin_o}, 64'h8000);
    chk("R1 lo field", {48'd0, lo_pin_o}, 64'h8001);

    // R7: no strobe, inputs wiggle in both modes
    @(negedge clk);
    sum_in = 35'h7_FFFF_FFFF; preload = 1'b1;
    ext_oe_n = 1'b1; hi_oe_n = 1'b1; lo_oe_n = 1'b1;
    {ext_pin_i, hi_pin_i, lo_pin_i} = 35'h1_1111_1111;
    repeat (3) @(negedge clk);
    preload = 1'b0;
    repeat (3) @(negedge clk);
    readback("R7 hold without strobe", 35'h4_8000_8001);

    // R9: reset mid-run
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    readback("R9 reset after data", 35'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule